// File: doc/BRIEF.md
# SPI Slave with Indirect Memory Window

This block is a serial slave that lets a host reach a 256-byte on-chip memory through two registers. One register holds the memory address pointer. The other is a data window onto the byte at that address. Each transfer begins when chip select goes low and ends when it goes high. The first byte of a transfer is a command: bit 7 gives the direction and bits 6:0 give the register index. The data bytes that follow go to, or come from, the selected register.

Streaming through the memory works as follows. When a burst targets the data window, the register index stays on the window. The memory address pointer advances after every complete byte and wraps from FFh to 00h. A burst on any other register instead walks the register index. A small control register holds one writable bit.

The serial pins are sampled by the system clock, so the block runs in a single clock domain. The host may idle the serial clock low or high. The block reads the idle level at the moment chip select falls.

Top module: `spi_sram_window`

## Requirements
- R1: A transfer starts when `spiCsN` falls and ends when it rises. Bits travel MSB first in 8-bit bytes. The first byte of each transfer is the command byte and every later byte is data.
- R2: In the command byte, bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6:0 are the register index: 18h is the memory address register, 19h is the data window and 13h is the control register. The write codes are therefore 98h, 99h and 93h. A read-coded transfer never changes any register.
- R3: The serial clock level seen when `spiCsN` falls sets the idle polarity. `spiMosi` is sampled on the first edge away from idle and on every such edge after it. `spiMiso` changes only on the opposite edge. Both idle levels work.
- R4: Writing register 18h loads the memory address pointer, and reading 18h returns it.
- R5: Writing register 19h stores the byte at the memory address, and reading 19h returns the byte at that address. After each complete data byte on 19h, the memory address advances by one while the register index stays at 19h.
- R6: The memory address wraps from FFh to 00h, on both reads and writes.
- R7: After each complete data byte on any register other than 19h, the register index advances by one and wraps from 7Fh to 00h.
- R8: Bit 0 of register 13h is readable and writable, and bits 7:1 read as 0.
- R9: Any index other than 13h, 18h and 19h reads as 00h and ignores writes.
- R10: `spiMisoOe` is 0 during the command byte, during write transfers and while chip select is high. It is 1 from the first bit of the first read data byte until the transfer ends.
- R11: When a transfer ends part-way through a byte, that byte stores nothing and does not advance the memory address.
- R12: After reset the memory address is 00h, the control bit is 0 and `spiMisoOe` is 0. Memory contents are undefined after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also samples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| spiCsN | input | 1 | Active-low chip select that frames a transfer |
| spiSclk | input | 1 | Serial clock from the host |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial data to the host |
| spiMisoOe | output | 1 | Output enable for `spiMiso` (1 = drive) |

## Verification
Two updates can land in the same clock cycle. When a write burst completes a byte on register 18h, the memory address is loaded and the register index steps to the data window at that same edge. The next byte must then land at the address that was just loaded.

The bench provokes this with a write burst that starts on an unused index, crosses 18h and continues into 19h. It judges the result by reading back the address register, the memory byte at the loaded address and the unused indices. Aborted bytes are also ended inside a byte, and the bench then checks that neither the pointer nor the memory changed.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

  localparam int BYTE_W = 8;

  // One-cycle strobes from the serial control to the datapath.
  typedef struct packed {
    logic              ptrLoad;   // command byte complete
    logic              wrCommit;  // write data byte complete
    logic              rdAdvance; // read data byte complete
    logic              txLoad;    // load next read byte into shifter
    logic              txShift;   // shift the output shifter
    logic              frameEnd;  // chip select released
    logic [BYTE_W-1:0] rxByte;    // byte assembled from the serial input
  } stbT;

endpackage

// File: rtl/spi_sram_mem.sv
module spi_sram_mem #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] store [DEPTH];

  // No reset: contents are undefined until written.
  always_ff @(posedge clk) begin
    if (wrEn) store[addr] <= wrData;
  end

  assign rdData = store[addr];

endmodule

// File: rtl/spi_sram_ctrl.sv
module spi_sram_ctrl
  import spi_sram_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiCsN,
  input  logic spiSclk,
  input  logic spiMosi,
  output stbT  stb,
  output logic csActive
);

  localparam int BITS_W = $clog2(BYTE_W);
  localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csSh, sclkSh, mosiSh;
  logic csSync, sclkSync, mosiSync;
  logic sclkPrev;
  logic cpol;
  logic inFrame;
  logic sclkRise, sclkFall, leadEdge, trailEdge;
  logic [BITS_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftIn, rxNext;
  logic dataPhase, wrMode;
  logic byteDone;

  // Input synchronizers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSh   <= '1;
      sclkSh <= '0;
      mosiSh <= '0;
    end else begin
      csSh[0]   <= spiCsN;
      sclkSh[0] <= spiSclk;
      mosiSh[0] <= spiMosi;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        csSh[s]   <= csSh[s-1];
        sclkSh[s] <= sclkSh[s-1];
        mosiSh[s] <= mosiSh[s-1];
      end
    end
  end

  assign csSync   = csSh[SYNC_STAGES-1];
  assign sclkSync = sclkSh[SYNC_STAGES-1];
  assign mosiSync = mosiSh[SYNC_STAGES-1];

  // Frame tracking and polarity capture at chip-select assertion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csActive <= 1'b0;
      sclkPrev <= 1'b0;
      cpol     <= 1'b0;
    end else begin
      csActive <= !csSync;
      sclkPrev <= sclkSync;
      if (!csActive && !csSync) cpol <= sclkSync;
    end
  end

  assign inFrame   = csActive && !csSync;
  assign sclkRise  = sclkSync && !sclkPrev;
  assign sclkFall  = !sclkSync && sclkPrev;
  assign leadEdge  = inFrame && (cpol ? sclkFall : sclkRise);
  assign trailEdge = inFrame && (cpol ? sclkRise : sclkFall);

  assign rxNext   = {shiftIn[BYTE_W-2:0], mosiSync};
  assign byteDone = leadEdge && (bitCnt == LAST_BIT);

  // Bit counter, input shifter and frame phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftIn   <= '0;
      dataPhase <= 1'b0;
      wrMode    <= 1'b0;
    end else if (!inFrame) begin
      bitCnt    <= '0;
      dataPhase <= 1'b0;
      wrMode    <= 1'b0;
    end else if (leadEdge) begin
      shiftIn <= rxNext;
      bitCnt  <= bitCnt + BITS_W'(1);
      if (byteDone && !dataPhase) begin
        dataPhase <= 1'b1;
        wrMode    <= rxNext[BYTE_W-1];
      end
    end
  end

  logic loadCond;
  assign loadCond = trailEdge && (bitCnt == '0) && dataPhase && !wrMode;

  always_comb begin
    stb           = '0;
    stb.rxByte    = rxNext;
    stb.ptrLoad   = byteDone && !dataPhase;
    stb.wrCommit  = byteDone && dataPhase && wrMode;
    stb.rdAdvance = byteDone && dataPhase && !wrMode;
    stb.txLoad    = loadCond;
    stb.txShift   = trailEdge && !loadCond;
    stb.frameEnd  = csActive && csSync;
  end

endmodule

// File: rtl/spi_sram_dp.sv
module spi_sram_dp
  import spi_sram_pkg::*;
#(
  parameter int MEM_DEPTH = 256,
  parameter int IDX_W     = 7,
  parameter logic [IDX_W-1:0] CTL_IDX  = 'h13,
  parameter logic [IDX_W-1:0] ADDR_IDX = 'h18,
  parameter logic [IDX_W-1:0] DATA_IDX = 'h19
) (
  input  logic clk,
  input  logic rstN,
  input  stbT  stb,
  output logic spiMiso,
  output logic spiMisoOe
);

  localparam int MA_W = $clog2(MEM_DEPTH);

  logic [IDX_W-1:0]  regIdx;
  logic [MA_W-1:0]   memAddr;
  logic              ctlBit;
  logic [BYTE_W-1:0] txSh;
  logic [BYTE_W-1:0] memRd;
  logic [BYTE_W-1:0] rdData;
  logic              memWe;
  logic              onWindow;
  logic              byteStep;

  assign onWindow = (regIdx == DATA_IDX);
  assign byteStep = stb.wrCommit || stb.rdAdvance;
  assign memWe    = stb.wrCommit && onWindow;

  spi_sram_mem #(
    .DEPTH (MEM_DEPTH),
    .WIDTH (BYTE_W)
  ) uMem (
    .clk    (clk),
    .wrEn   (memWe),
    .addr   (memAddr),
    .wrData (stb.rxByte),
    .rdData (memRd)
  );

  // Register index: loaded by the command byte, walks except on the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regIdx <= '0;
    end else if (stb.ptrLoad) begin
      regIdx <= stb.rxByte[IDX_W-1:0];
    end else if (byteStep && !onWindow) begin
      regIdx <= regIdx + IDX_W'(1);
    end
  end

  // Memory address: loaded through its register, advanced by the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
    end else if (stb.wrCommit && regIdx == ADDR_IDX) begin
      memAddr <= stb.rxByte[MA_W-1:0];
    end else if (byteStep && onWindow) begin
      memAddr <= memAddr + MA_W'(1);
    end
  end

  // Control bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlBit <= 1'b0;
    end else if (stb.wrCommit && regIdx == CTL_IDX) begin
      ctlBit <= stb.rxByte[0];
    end
  end

  // Read decode
  always_comb begin
    rdData = '0;
    if (regIdx == ADDR_IDX)      rdData = BYTE_W'(memAddr);
    else if (regIdx == DATA_IDX) rdData = memRd;
    else if (regIdx == CTL_IDX)  rdData = {{(BYTE_W-1){1'b0}}, ctlBit};
  end

  // Output shifter and driver enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh      <= '0;
      spiMisoOe <= 1'b0;
    end else begin
      if (stb.txLoad) begin
        txSh      <= rdData;
        spiMisoOe <= 1'b1;
      end else if (stb.txShift) begin
        txSh <= {txSh[BYTE_W-2:0], 1'b0};
      end
      if (stb.frameEnd) spiMisoOe <= 1'b0;
    end
  end

  assign spiMiso = txSh[BYTE_W-1];

endmodule

// File: rtl/spi_sram_window.sv
module spi_sram_window
  import spi_sram_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MEM_DEPTH   = 256,
  parameter int IDX_W       = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiCsN,
  input  logic spiSclk,
  input  logic spiMosi,
  output logic spiMiso,
  output logic spiMisoOe
);

  stbT  stb;
  logic csActive;

  spi_sram_ctrl #(
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .spiCsN   (spiCsN),
    .spiSclk  (spiSclk),
    .spiMosi  (spiMosi),
    .stb      (stb),
    .csActive (csActive)
  );

  spi_sram_dp #(
    .MEM_DEPTH (MEM_DEPTH),
    .IDX_W     (IDX_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .spiMiso   (spiMiso),
    .spiMisoOe (spiMisoOe)
  );

endmodule

// File: rtl/spi_sram_window_chk.sv
module spi_sram_window_chk (
  input logic clk,
  input logic rstN,
  input logic csActive,
  input logic ptrLoad,
  input logic wrCommit,
  input logic rdAdvance,
  input logic txLoad,
  input logic txShift,
  input logic frameEnd,
  input logic spiMiso,
  input logic spiMisoOe
);

  // R1: at most one frame event per cycle
  assert_one_event_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ptrLoad, wrCommit, rdAdvance, txLoad, txShift, frameEnd}));

  // R10: driver off outside a transfer
  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !spiMisoOe);

  // R10: driver turns on only with a read byte load
  assert_oe_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiMisoOe) |-> $past(txLoad));

  // R3: output data moves only on load or shift
  assert_miso_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(txLoad || txShift) |-> $stable(spiMiso));

  // R11: byte completions happen only inside a transfer
  assert_commit_in_frame_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ptrLoad || wrCommit || rdAdvance) |-> csActive);

endmodule

bind spi_sram_window spi_sram_window_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .csActive  (csActive),
  .ptrLoad   (stb.ptrLoad),
  .wrCommit  (stb.wrCommit),
  .rdAdvance (stb.rdAdvance),
  .txLoad    (stb.txLoad),
  .txShift   (stb.txShift),
  .frameEnd  (stb.frameEnd),
  .spiMiso   (spiMiso),
  .spiMisoOe (spiMisoOe)
);

// File: tb/sim_spi_sram_window.sv
`timescale 1ns/1ps
module sim_spi_sram_window;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1;
  logic spiSclk = 1'b0;
  logic spiMosi = 1'b0;
  logic spiMiso, spiMisoOe;

  logic cpol = 1'b0;
  int total = 0;
  int bad = 0;
  logic [7:0] expMem [256];
  logic [7:0] rxB;
  logic [1:0] oeI;   // {all-high, any-high} over sampled bits
  logic oeAcc;

  always #2 clk = ~clk;

  spi_sram_window u0 (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiMisoOe(spiMisoOe)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frameBegin();
    spiSclk = cpol;
    waitHalf(); waitHalf();
    spiCsN = 1'b0;
    waitHalf(); waitHalf();
    oeAcc = 1'b0;
  endtask

  task automatic frameEnd();
    waitHalf();
    spiCsN = 1'b1;
    waitHalf(); waitHalf();
    chkEq("R10 oe after frame", int'(spiMisoOe), 0);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb);
    logic [7:0] r = '0;
    logic all1 = 1'b1, any1 = 1'b0;
    for (int i = 0; i < nb; i++) begin
      spiMosi = tx[7-i];
      waitHalf();
      r = {r[6:0], spiMiso};
      all1 &= spiMisoOe;
      any1 |= spiMisoOe;
      spiSclk = ~cpol;
      waitHalf();
      spiSclk = cpol;
    end
    rxB = r;
    oeI = {all1, any1};
    oeAcc |= any1;
  endtask

  task automatic readReg(input logic [7:0] idx, input int exp, input string tag);
    frameBegin();
    xfer(idx, 8);
    chkEq({tag, " oe in command byte R10"}, int'(oeI[0]), 0);
    xfer(8'h00, 8);
    chkEq(tag, int'(rxB), exp);
    frameEnd();
  endtask

  task automatic setAddr(input logic [7:0] a);
    frameBegin();
    xfer(8'h98, 8);
    xfer(a, 8);
    frameEnd();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    chkEq("R12 oe in reset", int'(spiMisoOe), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chkEq("R12 oe after reset", int'(spiMisoOe), 0);

    // Reset values, idle-low clock
    cpol = 1'b0;
    readReg(8'h18, 8'h00, "R12 R4 addr reset");
    readReg(8'h13, 8'h00, "R12 R8 ctl reset");

    // Full write sweep with idle-low clock
    frameBegin();
    xfer(8'h98, 8);
    xfer(8'h00, 8);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] p = 8'((i * 37 + 11) & 255);
      xfer(p, 8);
      expMem[i] = p;
    end
    chkEq("R10 oe during write frame", int'(oeAcc), 0);
    frameEnd();
    readReg(8'h18, 8'h00, "R6 addr wrap after 256 writes");

    // Full read sweep with idle-high clock
    cpol = 1'b1;
    frameBegin();
    xfer(8'h19, 8);
    for (int i = 0; i < 256; i++) begin
      xfer(8'h00, 8);
      if (i == 0) chkEq("R10 oe on first read byte", int'(oeI[1]), 1);
      chkEq($sformatf("R5 R3 window read %0h", i), int'(rxB), int'(expMem[i]));
    end
    frameEnd();
    readReg(8'h18, 8'h00, "R6 addr wrap after 256 reads");

    // Write burst crossing FF->00, idle-high clock
    frameBegin();
    xfer(8'h98, 8);
    xfer(8'hF0, 8);
    for (int j = 0; j < 32; j++) begin
      logic [7:0] p = 8'((j ^ 8'hA5) + j);
      xfer(p, 8);
      expMem[(8'hF0 + j) & 255] = p;
    end
    frameEnd();
    readReg(8'h18, 8'h10, "R6 addr after wrapping write");

    // Read burst crossing FF->00, idle-low clock
    cpol = 1'b0;
    setAddr(8'hFE);
    frameBegin();
    xfer(8'h19, 8);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, 8);
      chkEq($sformatf("R5 R6 wrap read %0d", k), int'(rxB),
            int'(expMem[(8'hFE + k) & 255]));
    end
    frameEnd();
    readReg(8'h18, 8'h02, "R5 addr after read burst");

    // Read-coded command with data on the input changes nothing
    frameBegin();
    xfer(8'h18, 8);
    xfer(8'h33, 8);
    chkEq("R2 read of addr", int'(rxB), 8'h02);
    frameEnd();
    readReg(8'h18, 8'h02, "R2 read code did not write");

    // Control register
    frameBegin(); xfer(8'h93, 8); xfer(8'hFF, 8); frameEnd();
    readReg(8'h13, 8'h01, "R8 ctl set, upper bits zero");
    frameBegin(); xfer(8'h93, 8); xfer(8'hFE, 8); frameEnd();
    readReg(8'h13, 8'h00, "R8 ctl clear");
    frameBegin(); xfer(8'h93, 8); xfer(8'h01, 8); frameEnd();

    // Register walk from 13h across unused indices into the window
    cpol = 1'b1;
    frameBegin();
    xfer(8'h13, 8);
    for (int k = 0; k < 8; k++) begin
      int e;
      xfer(8'h00, 8);
      case (k)
        0: e = 1;
        5: e = 8'h02;
        6: e = int'(expMem[2]);
        7: e = int'(expMem[3]);
        default: e = 0;
      endcase
      chkEq($sformatf("R7 R9 walk from 13h byte %0d", k), int'(rxB), e);
    end
    frameEnd();
    readReg(8'h18, 8'h04, "R5 walk advanced addr only on window");

    // Index wrap 7Fh -> 00h
    frameBegin();
    xfer(8'h7F, 8);
    for (int k = 0; k < 22; k++) begin
      xfer(8'h00, 8);
      chkEq($sformatf("R7 index wrap byte %0d", k), int'(rxB), (k == 20) ? 1 : 0);
    end
    frameEnd();

    // Write walk: unused 15h..17h, then addr, then window (same-cycle update)
    frameBegin();
    xfer(8'h95, 8);
    xfer(8'hAA, 8); xfer(8'hBB, 8); xfer(8'hCC, 8);
    xfer(8'h40, 8);
    xfer(8'h5E, 8);
    frameEnd();
    expMem[8'h40] = 8'h5E;
    readReg(8'h18, 8'h41, "R7 R4 addr loaded in write walk");
    frameBegin();
    xfer(8'h15, 8);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, 8);
      chkEq($sformatf("R9 unused reads zero %0d", k), int'(rxB), 0);
    end
    frameEnd();
    setAddr(8'h40);
    readReg(8'h19, 8'h5E, "R5 data at loaded addr");

    // Aborted write byte
    cpol = 1'b0;
    setAddr(8'h40);
    frameBegin(); xfer(8'h99, 8); xfer(8'hC3, 5); frameEnd();
    readReg(8'h18, 8'h40, "R11 aborted write kept addr");
    readReg(8'h19, 8'h5E, "R11 aborted write stored nothing");

    // Aborted read byte
    setAddr(8'h40);
    frameBegin(); xfer(8'h19, 8); xfer(8'h00, 4); frameEnd();
    readReg(8'h18, 8'h40, "R11 aborted read kept addr");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule